// File: doc/BRIEF.md
# Dual-Clock Multichannel Sample Histogrammer

This block counts how often each ADC code occurs, separately for each of several channels, while samples keep arriving. Every valid sample adds one to the bin addressed by its code. The bins sit in two banks per channel. One bank takes updates in the acquisition clock domain while the other is held still so a host in the system clock domain can read it and then wipe it. The update is a pipelined read-modify-write. When one bin is hit on back-to-back cycles, the count in flight is forwarded to the next update instead of re-reading the old value from storage.

The host controls the block from the system clock domain. It asks for a bank exchange, reads every bin of the exposed bank with a fixed latency, and then starts a sweep that wipes that bank. Exchange requests and their acknowledgements cross between the clocks as toggles through two-flop synchronizers. The acquisition side switches banks on a single edge, so no valid sample is ever dropped. A new exchange is only accepted once the exposed bank has been wiped.

Top module: `hist_top`

## Requirements
- R1: After reset every bin of both banks of every channel holds zero, and swap_busy, clear_busy, swap_refused and rd_valid are low.
- R2: Each cycle with smp_valid[c] high adds one to bin smp_code[c*CODE_W +: CODE_W] of channel c in the bank currently accumulating; other channels and bins are untouched.
- R3: Samples that hit the same bin on consecutive acquisition cycles are each counted, with no update lost.
- R4: A bin count stops at 2^CNT_W-1 and stays there on further hits.
- R5: A swap_req pulse accepted while the block is ready raises swap_busy on the next system edge. swap_busy falls once the exchange has taken effect in both domains, and reads then return the bank that had been accumulating.
- R6: Every valid sample is counted exactly once, in one bank, including samples that arrive during a bank exchange.
- R7: A swap_req while an exchange is pending, a wipe is running, or the exposed bank has not been wiped since the last exchange is refused. swap_refused is high for one cycle after the request, swap_busy stays low if it was low, and the exposed counts are unchanged.
- R8: clear_start, when no exchange or wipe is in progress and swap_req is low, raises clear_busy for exactly 2^CODE_W system cycles. Afterwards every bin of the exposed bank reads zero and a new exchange is accepted.
- R9: A read with rd_en high at a system edge returns rd_valid high and the count of bin rd_bin of channel rd_chan in the exposed bank two system edges later. rd_valid is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acq_clk | input | 1 | Acquisition clock |
| acq_rst_n | input | 1 | Asynchronous active-low reset, acquisition domain |
| smp_valid | input | N_CH | Per-channel sample strobe |
| smp_code | input | N_CH*CODE_W | Per-channel sample codes, channel c at bits c*CODE_W upward |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| swap_req | input | 1 | One-cycle request to exchange banks |
| clear_start | input | 1 | One-cycle request to wipe the exposed bank |
| rd_en | input | 1 | Read strobe |
| rd_chan | input | CH_W | Channel to read |
| rd_bin | input | CODE_W | Bin to read |
| swap_busy | output | 1 | Exchange in flight |
| clear_busy | output | 1 | Wipe sweep running |
| swap_refused | output | 1 | One-cycle flag for a refused exchange |
| rd_valid | output | 1 | Read data valid |
| rd_count | output | CNT_W | Count returned by a read |

## Verification
The bench builds the block with two channels, 4-bit codes and 4-bit counters. With these values every bin can be read back exhaustively after each exchange, and a count reaches its ceiling of 15 after a short run of hits. The wipe sweep lasts only 16 cycles, so its exact length is measured. The acquisition clock is slower than the system clock and unrelated to it. A stream of samples is kept running across an exchange, and the counts in the two banks must add up to the length of the stream.

// File: rtl/hist_pkg.sv
`timescale 1ns/1ps
package hist_pkg;
    typedef enum logic [1:0] {
        PH_READY = 2'd0,
        PH_SWAP  = 2'd1,
        PH_READ  = 2'd2,
        PH_CLEAR = 2'd3
    } phase_e;
endpackage

// File: rtl/hist_sync.sv
`timescale 1ns/1ps
module hist_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [1:0] s_d, s_q;

    always_comb begin
        s_d = {s_q[0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q[1];
endmodule

// File: rtl/hist_acq_ctrl.sv
`timescale 1ns/1ps
module hist_acq_ctrl (
    input  logic acq_clk,
    input  logic acq_rst_n,
    input  logic req_tgl_s,
    output logic act_bank,
    output logic ack_tgl
);
    typedef struct packed {
        logic seen;
        logic bank;
        logic ack1;
        logic ack;
    } actl_t;

    actl_t d, q;

    always_comb begin
        d      = q;
        d.seen = req_tgl_s;
        d.bank = q.bank ^ (req_tgl_s != q.seen);
        // acknowledge only after the last old-bank write has landed
        d.ack1 = q.seen;
        d.ack  = q.ack1;
    end

    always_ff @(posedge acq_clk or negedge acq_rst_n) begin
        if (!acq_rst_n) q <= '0;
        else            q <= d;
    end

    assign act_bank = q.bank;
    assign ack_tgl  = q.ack;
endmodule

// File: rtl/hist_chan.sv
`timescale 1ns/1ps
module hist_chan #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              acq_clk,
    input  logic              acq_rst_n,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              act_bank,
    input  logic              clr_we,
    input  logic              clr_bank,
    input  logic [CODE_W-1:0] clr_bin,
    input  logic              rd_bank,
    input  logic [CODE_W-1:0] rd_bin,
    output logic [CNT_W-1:0]  rd_count
);
    localparam int BINS = 1 << CODE_W;

    typedef struct packed {
        logic              v1;
        logic              b1;
        logic [CODE_W-1:0] a1;
        logic              z1;
        logic [CNT_W-1:0]  r1;
        logic              v2;
        logic              b2;
        logic [CODE_W-1:0] a2;
        logic [CNT_W-1:0]  c2;
    } pipe_t;

    pipe_t d, q;

    logic [CNT_W-1:0]     mem [2][BINS];
    logic [1:0][BINS-1:0] acq_tag_q;
    logic [1:0][BINS-1:0] clr_tag_q;

    logic             hit;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] newc;

    // a bin reads as zero while its two tags agree
    always_comb begin
        hit  = q.v2 && (q.b2 == q.b1) && (q.a2 == q.a1);
        base = hit ? q.c2 : (q.z1 ? '0 : q.r1);
        newc = (&base) ? base : base + 1'b1;

        d    = q;
        d.v1 = smp_valid;
        d.b1 = act_bank;
        d.a1 = smp_code;
        d.r1 = mem[act_bank][smp_code];
        d.z1 = acq_tag_q[act_bank][smp_code] == clr_tag_q[act_bank][smp_code];
        d.v2 = q.v1;
        d.b2 = q.b1;
        d.a2 = q.a1;
        d.c2 = newc;
    end

    always_ff @(posedge acq_clk or negedge acq_rst_n) begin
        if (!acq_rst_n) q <= '0;
        else            q <= d;
    end

    always_ff @(posedge acq_clk) begin
        if (q.v1) mem[q.b1][q.a1] <= newc;
    end

    always_ff @(posedge acq_clk or negedge acq_rst_n) begin
        if (!acq_rst_n)  acq_tag_q <= '0;
        else if (q.v1)   acq_tag_q[q.b1][q.a1] <= ~clr_tag_q[q.b1][q.a1];
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n)  clr_tag_q <= '0;
        else if (clr_we) clr_tag_q[clr_bank][clr_bin] <= acq_tag_q[clr_bank][clr_bin];
    end

    assign rd_count = (acq_tag_q[rd_bank][rd_bin] == clr_tag_q[rd_bank][rd_bin])
                      ? '0 : mem[rd_bank][rd_bin];
endmodule

// File: rtl/hist_sys_ctrl.sv
`timescale 1ns/1ps
module hist_sys_ctrl
    import hist_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 32,
    parameter int CH_W   = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              swap_req,
    input  logic              clear_start,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic [CODE_W-1:0] rd_bin,
    input  logic              ack_tgl_s,
    input  logic [CNT_W-1:0]  sel_count,
    output logic              req_tgl,
    output logic              exp_bank,
    output logic              clr_we,
    output logic [CODE_W-1:0] clr_bin,
    output logic [CH_W-1:0]   rd_ch_q,
    output logic [CODE_W-1:0] rd_bin_q,
    output logic              swap_busy,
    output logic              clear_busy,
    output logic              swap_refused,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_count
);
    typedef struct packed {
        phase_e            phase;
        logic              req_tgl;
        logic              bank;
        logic [CODE_W-1:0] ptr;
        logic              refused;
        logic              r_en;
        logic [CH_W-1:0]   r_ch;
        logic [CODE_W-1:0] r_bin;
        logic              o_valid;
        logic [CNT_W-1:0]  o_cnt;
    } sctl_t;

    sctl_t d, q;

    always_comb begin
        d         = q;
        d.refused = 1'b0;
        unique case (q.phase)
            PH_READY: begin
                if (swap_req) begin
                    d.req_tgl = ~q.req_tgl;
                    d.phase   = PH_SWAP;
                end else if (clear_start) begin
                    d.ptr   = '0;
                    d.phase = PH_CLEAR;
                end
            end
            PH_SWAP: begin
                d.refused = swap_req;
                if (ack_tgl_s == q.req_tgl) begin
                    d.bank  = ~q.bank;
                    d.phase = PH_READ;
                end
            end
            PH_READ: begin
                d.refused = swap_req;
                if (clear_start) begin
                    d.ptr   = '0;
                    d.phase = PH_CLEAR;
                end
            end
            PH_CLEAR: begin
                d.refused = swap_req;
                d.ptr     = q.ptr + 1'b1;
                if (&q.ptr) d.phase = PH_READY;
            end
            default: d.phase = PH_READY;
        endcase

        d.r_en    = rd_en;
        d.r_ch    = rd_chan;
        d.r_bin   = rd_bin;
        d.o_valid = q.r_en;
        d.o_cnt   = q.r_en ? sel_count : q.o_cnt;
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            q      <= '0;
            q.bank <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_tgl      = q.req_tgl;
    assign exp_bank     = q.bank;
    assign clr_we       = (q.phase == PH_CLEAR);
    assign clr_bin      = q.ptr;
    assign rd_ch_q      = q.r_ch;
    assign rd_bin_q     = q.r_bin;
    assign swap_busy    = (q.phase == PH_SWAP);
    assign clear_busy   = (q.phase == PH_CLEAR);
    assign swap_refused = q.refused;
    assign rd_valid     = q.o_valid;
    assign rd_count     = q.o_cnt;
endmodule

// File: rtl/hist_top.sv
`timescale 1ns/1ps
module hist_top #(
    parameter int N_CH   = 4,
    parameter int CODE_W = 8,
    parameter int CNT_W  = 32,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                     acq_clk,
    input  logic                     acq_rst_n,
    input  logic [N_CH-1:0]          smp_valid,
    input  logic [N_CH*CODE_W-1:0]   smp_code,
    input  logic                     sys_clk,
    input  logic                     sys_rst_n,
    input  logic                     swap_req,
    input  logic                     clear_start,
    input  logic                     rd_en,
    input  logic [CH_W-1:0]          rd_chan,
    input  logic [CODE_W-1:0]        rd_bin,
    output logic                     swap_busy,
    output logic                     clear_busy,
    output logic                     swap_refused,
    output logic                     rd_valid,
    output logic [CNT_W-1:0]         rd_count
);
    logic              req_tgl, req_tgl_s;
    logic              ack_tgl, ack_tgl_s;
    logic              act_bank, exp_bank;
    logic              clr_we;
    logic [CODE_W-1:0] clr_bin;
    logic [CH_W-1:0]   rd_ch_q;
    logic [CODE_W-1:0] rd_bin_q;
    logic [CNT_W-1:0]  sel_count;
    logic [CNT_W-1:0]  ch_cnt [N_CH];

    hist_sync u_req_sync (
        .clk(acq_clk), .rst_n(acq_rst_n), .d(req_tgl), .q(req_tgl_s)
    );

    hist_sync u_ack_sync (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(ack_tgl), .q(ack_tgl_s)
    );

    hist_acq_ctrl u_acq (
        .acq_clk   (acq_clk),
        .acq_rst_n (acq_rst_n),
        .req_tgl_s (req_tgl_s),
        .act_bank  (act_bank),
        .ack_tgl   (ack_tgl)
    );

    hist_sys_ctrl #(.CODE_W(CODE_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_sys (
        .sys_clk      (sys_clk),
        .sys_rst_n    (sys_rst_n),
        .swap_req     (swap_req),
        .clear_start  (clear_start),
        .rd_en        (rd_en),
        .rd_chan      (rd_chan),
        .rd_bin       (rd_bin),
        .ack_tgl_s    (ack_tgl_s),
        .sel_count    (sel_count),
        .req_tgl      (req_tgl),
        .exp_bank     (exp_bank),
        .clr_we       (clr_we),
        .clr_bin      (clr_bin),
        .rd_ch_q      (rd_ch_q),
        .rd_bin_q     (rd_bin_q),
        .swap_busy    (swap_busy),
        .clear_busy   (clear_busy),
        .swap_refused (swap_refused),
        .rd_valid     (rd_valid),
        .rd_count     (rd_count)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        hist_chan #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chan (
            .acq_clk   (acq_clk),
            .acq_rst_n (acq_rst_n),
            .sys_clk   (sys_clk),
            .sys_rst_n (sys_rst_n),
            .smp_valid (smp_valid[c]),
            .smp_code  (smp_code[c*CODE_W +: CODE_W]),
            .act_bank  (act_bank),
            .clr_we    (clr_we),
            .clr_bank  (exp_bank),
            .clr_bin   (clr_bin),
            .rd_bank   (exp_bank),
            .rd_bin    (rd_bin_q),
            .rd_count  (ch_cnt[c])
        );
    end

    always_comb begin
        sel_count = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (rd_ch_q == CH_W'(i)) sel_count = ch_cnt[i];
        end
    end
endmodule

// File: rtl/hist_checker.sv
`timescale 1ns/1ps
module hist_checker (
    input logic sys_clk,
    input logic sys_rst_n,
    input logic swap_req,
    input logic clear_start,
    input logic rd_en,
    input logic swap_busy,
    input logic clear_busy,
    input logic swap_refused,
    input logic rd_valid
);
    p_phase_excl_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !(swap_busy && clear_busy));

    p_refuse_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        swap_req && (swap_busy || clear_busy) |=> swap_refused);

    p_refuse_norise_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        swap_refused |-> !$rose(swap_busy));

    p_clear_start_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        clear_start && !swap_req && !swap_busy && !clear_busy |=> clear_busy);

    p_rd_lat_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        rd_en |-> ##2 rd_valid);

    p_rd_only_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        rd_valid |-> $past(rd_en, 2));
endmodule

bind hist_top hist_checker u_chk (
    .sys_clk      (sys_clk),
    .sys_rst_n    (sys_rst_n),
    .swap_req     (swap_req),
    .clear_start  (clear_start),
    .rd_en        (rd_en),
    .swap_busy    (swap_busy),
    .clear_busy   (clear_busy),
    .swap_refused (swap_refused),
    .rd_valid     (rd_valid)
);

// File: tb/tb_hist_top.sv
`timescale 1ns/1ps
module tb_hist_top;
    localparam int N_CH   = 2;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 4;
    localparam int BINS   = 1 << CODE_W;
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic                   acq_clk = 1'b0;
    logic                   sys_clk = 1'b0;
    logic                   acq_rst_n = 1'b0;
    logic                   sys_rst_n = 1'b0;
    logic [N_CH-1:0]        smp_valid = '0;
    logic [N_CH*CODE_W-1:0] smp_code = '0;
    logic                   swap_req = 1'b0;
    logic                   clear_start = 1'b0;
    logic                   rd_en = 1'b0;
    logic [0:0]             rd_chan = '0;
    logic [CODE_W-1:0]      rd_bin = '0;
    logic                   swap_busy, clear_busy, swap_refused, rd_valid;
    logic [CNT_W-1:0]       rd_count;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_cur [2][BINS];
    int exp_out [2][BINS];

    always #5  sys_clk = ~sys_clk;
    always #12 acq_clk = ~acq_clk;

    hist_top #(.N_CH(N_CH), .CODE_W(CODE_W), .CNT_W(CNT_W)) dut (
        .acq_clk(acq_clk), .acq_rst_n(acq_rst_n), .smp_valid(smp_valid),
        .smp_code(smp_code), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .swap_req(swap_req), .clear_start(clear_start), .rd_en(rd_en),
        .rd_chan(rd_chan), .rd_bin(rd_bin), .swap_busy(swap_busy),
        .clear_busy(clear_busy), .swap_refused(swap_refused),
        .rd_valid(rd_valid), .rd_count(rd_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic v0, input logic [CODE_W-1:0] c0,
                        input logic v1, input logic [CODE_W-1:0] c1);
        @(negedge acq_clk);
        smp_valid = {v1, v0};
        smp_code  = {c1, c0};
        if (v0 && exp_cur[0][c0] < MAXC) exp_cur[0][c0]++;
        if (v1 && exp_cur[1][c1] < MAXC) exp_cur[1][c1]++;
    endtask

    task automatic acq_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge acq_clk);
            smp_valid = '0;
        end
    endtask

    task automatic read_bin(input int ch, input int bin, output int cnt, output bit vld);
        @(negedge sys_clk);
        rd_en = 1'b1; rd_chan = 1'(ch); rd_bin = CODE_W'(bin);
        @(negedge sys_clk);
        rd_en = 1'b0;
        @(negedge sys_clk);
        cnt = int'(rd_count);
        vld = rd_valid;
    endtask

    task automatic do_swap(input string req);
        int guard;
        @(negedge sys_clk); swap_req = 1'b1;
        @(negedge sys_clk); swap_req = 1'b0;
        chk(swap_busy == 1'b1, req, "swap_busy after accepted request", int'(swap_busy), 1);
        guard = 0;
        while (swap_busy && guard < 100) begin
            @(negedge sys_clk); guard++;
        end
        chk(swap_busy == 1'b0, req, "swap completes", int'(swap_busy), 0);
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < BINS; b++) begin
                exp_out[c][b] = exp_cur[c][b];
                exp_cur[c][b] = 0;
            end
    endtask

    task automatic check_all(input string req);
        int cnt; bit vld; int bad;
        bad = 0;
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < BINS; b++) begin
                read_bin(c, b, cnt, vld);
                if (cnt != exp_out[c][b] || !vld) begin
                    bad++;
                    $display("FAIL %s ch%0d bin%0d actual=%0d expected=%0d", req, c, b, cnt, exp_out[c][b]);
                end
            end
        n_chk++;
        if (bad != 0) n_fail++;
    endtask

    task automatic do_clear(input bit probe_refuse);
        int busy_cyc;
        @(negedge sys_clk); clear_start = 1'b1;
        @(negedge sys_clk); clear_start = 1'b0;
        busy_cyc = 0;
        if (probe_refuse) begin
            chk(clear_busy == 1'b1, "R8", "clear_busy after start", int'(clear_busy), 1);
            busy_cyc++;
            swap_req = 1'b1;
            @(negedge sys_clk); swap_req = 1'b0;
            chk(swap_refused == 1'b1, "R7", "refused during wipe", int'(swap_refused), 1);
            chk(swap_busy == 1'b0, "R7", "no swap during wipe", int'(swap_busy), 0);
        end
        while (clear_busy && busy_cyc < 100) begin
            busy_cyc++;
            @(negedge sys_clk);
        end
        chk(busy_cyc == BINS, "R8", "wipe length", busy_cyc, BINS);
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < BINS; b++) exp_out[c][b] = 0;
    endtask

    task automatic t_reset;
        chk(!swap_busy && !clear_busy, "R1", "busy flags after reset", int'({swap_busy, clear_busy}), 0);
        chk(!swap_refused && !rd_valid, "R1", "refused/valid after reset", int'({swap_refused, rd_valid}), 0);
        check_all("R1");
    endtask

    task automatic t_basic;
        push(1, 4'd1, 1, 4'd7);
        push(1, 4'd2, 0, 4'd0);
        push(0, 4'd0, 1, 4'd7);
        push(1, 4'd2, 1, 4'd15);
        push(1, 4'd5, 1, 4'd7);
        push(1, 4'd0, 0, 4'd3);
        acq_idle(4);
        do_swap("R5");
        check_all("R2");
        do_clear(1'b0);
        check_all("R8");
    endtask

    task automatic t_fwd_sat;
        for (int i = 0; i < 20; i++) push(1, 4'd9, (i % 2) == 0, 4'd3);
        for (int i = 0; i < 6; i++)  push(1, 4'd4, 1, 4'd8);
        push(1, 4'd4, 1, 4'd3);
        push(1, 4'd9, 1, 4'd3);
        acq_idle(4);
        do_swap("R5");
        check_all("R3");
        chk(exp_out[0][9] == MAXC, "R4", "model ceiling", exp_out[0][9], MAXC);
        begin
            int cnt; bit vld;
            read_bin(0, 9, cnt, vld);
            chk(cnt == MAXC, "R4", "saturated bin", cnt, MAXC);
            @(negedge sys_clk); swap_req = 1'b1;
            @(negedge sys_clk); swap_req = 1'b0;
            chk(swap_refused == 1'b1, "R7", "refused while not wiped", int'(swap_refused), 1);
            chk(swap_busy == 1'b0, "R7", "no swap while not wiped", int'(swap_busy), 0);
            @(negedge sys_clk);
            chk(swap_refused == 1'b0, "R7", "refused is one cycle", int'(swap_refused), 0);
            read_bin(0, 4, cnt, vld);
            chk(cnt == 7, "R7", "exposed count unchanged", cnt, 7);
        end
        do_clear(1'b1);
    endtask

    task automatic t_latency;
        @(negedge sys_clk); rd_en = 1'b1; rd_chan = 1'b0; rd_bin = 4'd0;
        @(negedge sys_clk); rd_en = 1'b0;
        chk(rd_valid == 1'b0, "R9", "not valid after one edge", int'(rd_valid), 0);
        @(negedge sys_clk);
        chk(rd_valid == 1'b1, "R9", "valid after two edges", int'(rd_valid), 1);
        @(negedge sys_clk);
        chk(rd_valid == 1'b0, "R9", "valid lasts one cycle", int'(rd_valid), 0);
    endtask

    task automatic t_deadtime;
        int n1, n2; bit vld;
        fork
            begin
                for (int i = 0; i < 20; i++) push(1, 4'd2, 0, 4'd0);
                acq_idle(4);
            end
            begin
                repeat (20) @(negedge sys_clk);
                do_swap("R6");
                read_bin(0, 2, n1, vld);
                do_clear(1'b0);
            end
        join
        do_swap("R6");
        read_bin(0, 2, n2, vld);
        chk(n1 > 0 && n1 < 20, "R6", "swap fell inside stream", n1, 10);
        chk(n1 + n2 == 20, "R6", "samples across swap", n1 + n2, 20);
    endtask

    initial begin
        repeat (100000) @(posedge sys_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < BINS; b++) begin
                exp_cur[c][b] = 0;
                exp_out[c][b] = 0;
            end
        repeat (4) @(negedge acq_clk);
        acq_rst_n = 1'b1;
        @(negedge sys_clk);
        sys_rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        t_reset();
        t_basic();
        t_fwd_sat();
        t_latency();
        t_deadtime();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule